// File: doc/BRIEF.md
# OTP Parameter Area Read Sequencer

This block drives a byte-wide NAND command/address/data operation channel through a fixed script. The script reads a one-time-programmable parameter page into the host's buffer and then leaves the device in normal operation again. A single `start` pulse latches a page address and a byte count. The sequencer then resets the device and writes a private parameter register. It issues three entry commands, performs a page read of the requested length from column zero, and finally runs a restore script that ends with an empty dummy read of page zero.

Each device operation is presented on the operation channel and held until the channel acknowledges it. Low-level bus timing belongs to the channel, not to this block. Read bytes return one per acknowledge and leave on a valid-qualified byte stream. A failure flagged with any acknowledge stops the script at once and raises an error pulse. A clean finish raises a done pulse. The sequencer does not interpret the returned bytes.

Top module: `otp_param_reader`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `dataValid` and `opValid` are all low, and no operation is presented while idle.
- R2: After `start`, the first operations are: command 0xFF; a wait for `rbReady`; command 0x36; address 0x38; write 0x52; command 0x16. Operation kind codes on `opKind` are 0 = command, 1 = address, 2 = data write, 3 = data read.
- R3: Entry into the parameter area follows as commands 0x17, 0x04, 0x19, in that order.
- R4: The page read is command 0x00, then two address bytes of 0x00 (column), then three row address bytes taken from `pageAddr` least significant byte first, then command 0x30, then a wait for `rbReady`.
- R5: Exactly `byteCount` data-read operations follow. The byte returned on `opRdata` with each read acknowledge appears on `dataOut` with `dataValid` high in the next cycle. A count of zero produces no read operation.
- R6: The restore script follows: command 0xFF; a wait for `rbReady`; command 0x36; address 0x38; write 0x00; command 0x16; command 0x00; five address bytes of 0x00; command 0x30; a wait for `rbReady`. No data is read.
- R7: When `rbReady` is seen high in the final wait, `done` pulses for one cycle and `busy` falls in the same cycle. `done` and `error` are never high together.
- R8: An acknowledge with `opFail` high aborts the script: `error` pulses in the next cycle, `busy` falls, no further operation is presented, and `done` does not pulse.
- R9: A `start` received while busy is ignored: the running script and its latched page address and count are unchanged.
- R10: A presented operation keeps `opValid`, `opKind` and `opByte` stable until it is acknowledged.
- R11: During a wait step, no operation is presented and the script does not advance while `rbReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the script (ignored while busy) |
| pageAddr | input | 24 | Row address of the parameter page |
| byteCount | input | 16 | Number of bytes to read from the page |
| opValid | output | 1 | An operation is presented |
| opKind | output | 2 | 0 command, 1 address, 2 data write, 3 data read |
| opByte | output | 8 | Command, address or write byte (0 for reads) |
| opAck | input | 1 | The channel completed the presented operation |
| opFail | input | 1 | The acknowledged operation failed |
| opRdata | input | 8 | Byte returned with a read acknowledge |
| rbReady | input | 1 | Device ready/busy line, high when ready |
| dataOut | output | 8 | Parameter byte read from the page |
| dataValid | output | 1 | `dataOut` holds a new byte this cycle |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on abort |

## Verification
The two real page configurations, 0x21F with 784 bytes and 0x200 with 528 bytes, are run in full. They show that the counter ends at long lengths and that the row bytes go out in the right order. Random page addresses with short random lengths, random acknowledge delays and random ready/busy low times check that the script order holds under any channel pacing. The same runs check that each read byte pairs with its own acknowledge. A zero-length run separates "no reads" from "one read". Failures injected in the opening script, in the middle of the data phase and on the final command show that the abort stops the sequence wherever it occurs. A start pulse issued mid-run shows that the latched configuration is not disturbed.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

  typedef enum logic [2:0] {
    K_CMD  = 3'd0,
    K_ADDR = 3'd1,
    K_WR   = 3'd2,
    K_RD   = 3'd3,
    K_WAIT = 3'd4
  } stepKind_e;

  typedef struct packed {
    stepKind_e  kind;
    logic       isRow;
    logic [3:0] rowSel;
    logic [7:0] value;
  } step_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadCfg;
    logic       clrCount;
    logic       capture;
    logic       isRow;
    logic [3:0] rowSel;
    logic [7:0] value;
  } ctrlStrobe_t;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_PARAM   = 8'h36;
  localparam logic [7:0] OP_APPLY   = 8'h16;
  localparam logic [7:0] OP_ENTRY_A = 8'h17;
  localparam logic [7:0] OP_ENTRY_B = 8'h04;
  localparam logic [7:0] OP_ENTRY_C = 8'h19;
  localparam logic [7:0] OP_RD_SETUP = 8'h00;
  localparam logic [7:0] OP_RD_GO   = 8'h30;
  localparam logic [7:0] PRM_REG    = 8'h38;
  localparam logic [7:0] PRM_ON     = 8'h52;
  localparam logic [7:0] PRM_OFF    = 8'h00;

  function automatic int scriptLen(int colCyc, int rowCyc);
    return 22 + 2 * colCyc + 2 * rowCyc;
  endfunction

  // Step descriptor for script position idx.
  function automatic step_t scriptStep(int idx, int colCyc, int rowCyc);
    step_t s;
    int    rdBase;
    int    tailAddr;
    s.kind   = K_CMD;
    s.isRow  = 1'b0;
    s.rowSel = 4'd0;
    s.value  = 8'h00;
    rdBase   = 10 + colCyc + rowCyc;
    tailAddr = rdBase + 10 + colCyc + rowCyc;
    if (idx < 10) begin
      case (idx)
        0: s.value = OP_RESET;
        1: s.kind = K_WAIT;
        2: s.value = OP_PARAM;
        3: begin s.kind = K_ADDR; s.value = PRM_REG; end
        4: begin s.kind = K_WR; s.value = PRM_ON; end
        5: s.value = OP_APPLY;
        6: s.value = OP_ENTRY_A;
        7: s.value = OP_ENTRY_B;
        8: s.value = OP_ENTRY_C;
        default: s.value = OP_RD_SETUP;
      endcase
    end else if (idx < 10 + colCyc) begin
      s.kind = K_ADDR;
    end else if (idx < rdBase) begin
      s.kind   = K_ADDR;
      s.isRow  = 1'b1;
      s.rowSel = 4'(idx - 10 - colCyc);
    end else if (idx < rdBase + 10) begin
      case (idx - rdBase)
        0: s.value = OP_RD_GO;
        1: s.kind = K_WAIT;
        2: s.kind = K_RD;
        3: s.value = OP_RESET;
        4: s.kind = K_WAIT;
        5: s.value = OP_PARAM;
        6: begin s.kind = K_ADDR; s.value = PRM_REG; end
        7: begin s.kind = K_WR; s.value = PRM_OFF; end
        8: s.value = OP_APPLY;
        default: s.value = OP_RD_SETUP;
      endcase
    end else if (idx < tailAddr) begin
      s.kind = K_ADDR;
    end else if (idx == tailAddr) begin
      s.value = OP_RD_GO;
    end else begin
      s.kind = K_WAIT;
    end
    return s;
  endfunction

endpackage

// File: rtl/otp_rd_datapath.sv
module otp_rd_datapath
  import otp_rd_pkg::*;
#(
  parameter int ROW_CYCLES = 3,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ROW_CYCLES*8-1:0] pageAddr,
  input  logic [LEN_W-1:0]        byteCount,
  input  logic [7:0]              opRdata,
  output logic [7:0]              opByte,
  output logic                    lenZero,
  output logic                    lastByte,
  output logic [7:0]              dataOut,
  output logic                    dataValid
);
  localparam int ROW_BITS = ROW_CYCLES * 8;

  logic [ROW_BITS-1:0] pageReg;
  logic [LEN_W-1:0]    lenReg;
  logic [LEN_W-1:0]    readCount;
  logic [7:0]          rowByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg   <= '0;
      lenReg    <= '0;
      readCount <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (strobe.loadCfg) begin
        pageReg <= pageAddr;
        lenReg  <= byteCount;
      end
      if (strobe.clrCount) begin
        readCount <= '0;
      end else if (strobe.capture) begin
        readCount <= readCount + 1'b1;
      end
      dataValid <= strobe.capture;
      if (strobe.capture) begin
        dataOut <= opRdata;
      end
    end
  end

  always_comb begin
    rowByte  = 8'(pageReg >> {strobe.rowSel, 3'b000});
    opByte   = strobe.isRow ? rowByte : strobe.value;
    lenZero  = (lenReg == '0);
    lastByte = (readCount == lenReg - 1'b1);
  end

  // never capture beyond the configured length
  assert_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (readCount < lenReg));

  // configuration only changes on a load
  assert_cfg_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> ($stable(lenReg) && $stable(pageReg)));

endmodule

// File: rtl/otp_rd_ctrl.sv
module otp_rd_ctrl
  import otp_rd_pkg::*;
#(
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        opAck,
  input  logic        opFail,
  input  logic        rbReady,
  input  logic        lenZero,
  input  logic        lastByte,
  output logic        opValid,
  output logic [1:0]  opKind,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam int STEPS    = scriptLen(COL_CYCLES, ROW_CYCLES);
  localparam int IDX_W    = $clog2(STEPS);
  localparam int LAST_IDX = STEPS - 1;

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e           state, stateNxt;
  logic [IDX_W-1:0] stepIdx, stepIdxNxt;
  logic             doneNxt, errorNxt;
  step_t            cur;
  logic             waiting;

  always_comb begin
    cur     = scriptStep(int'(stepIdx), COL_CYCLES, ROW_CYCLES);
    waiting = (state == S_RUN) && (cur.kind == K_WAIT);
    busy    = (state == S_RUN);
    opKind  = cur.kind[1:0];
    opValid = 1'b0;
    if (state == S_RUN) begin
      case (cur.kind)
        K_WAIT:  opValid = 1'b0;
        K_RD:    opValid = !lenZero;
        default: opValid = 1'b1;
      endcase
    end

    strobe.loadCfg  = 1'b0;
    strobe.clrCount = 1'b0;
    strobe.capture  = 1'b0;
    strobe.isRow    = cur.isRow;
    strobe.rowSel   = cur.rowSel;
    strobe.value    = cur.value;

    stateNxt   = state;
    stepIdxNxt = stepIdx;
    doneNxt    = 1'b0;
    errorNxt   = 1'b0;

    if (state == S_IDLE) begin
      if (start) begin
        strobe.loadCfg  = 1'b1;
        strobe.clrCount = 1'b1;
        stateNxt        = S_RUN;
        stepIdxNxt      = '0;
      end
    end else begin
      if (cur.kind == K_WAIT) begin
        if (rbReady) begin
          if (int'(stepIdx) == LAST_IDX) begin
            stateNxt = S_IDLE;
            doneNxt  = 1'b1;
          end else begin
            stepIdxNxt = stepIdx + 1'b1;
          end
        end
      end else if (cur.kind == K_RD && lenZero) begin
        stepIdxNxt = stepIdx + 1'b1;
      end else if (opAck) begin
        if (opFail) begin
          stateNxt = S_IDLE;
          errorNxt = 1'b1;
        end else if (cur.kind == K_RD) begin
          strobe.capture = 1'b1;
          if (lastByte) stepIdxNxt = stepIdx + 1'b1;
        end else begin
          stepIdxNxt = stepIdx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      state   <= stateNxt;
      stepIdx <= stepIdxNxt;
      done    <= doneNxt;
      error   <= errorNxt;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !opValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opAck) |=> (opValid && $stable(opKind) && $stable(stepIdx)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opAck && opFail) |=> (error && !busy && !opValid));

  assert_wait_R11: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !rbReady) |=> (!opValid && $stable(stepIdx)));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

// File: rtl/otp_param_reader.sv
module otp_param_reader
  import otp_rd_pkg::*;
#(
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ROW_CYCLES*8-1:0] pageAddr,
  input  logic [LEN_W-1:0]        byteCount,
  output logic                    opValid,
  output logic [1:0]              opKind,
  output logic [7:0]              opByte,
  input  logic                    opAck,
  input  logic                    opFail,
  input  logic [7:0]              opRdata,
  input  logic                    rbReady,
  output logic [7:0]              dataOut,
  output logic                    dataValid,
  output logic                    busy,
  output logic                    done,
  output logic                    error
);
  ctrlStrobe_t strobe;
  logic        lenZero;
  logic        lastByte;

  otp_rd_ctrl #(
    .COL_CYCLES(COL_CYCLES),
    .ROW_CYCLES(ROW_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opAck   (opAck),
    .opFail  (opFail),
    .rbReady (rbReady),
    .lenZero (lenZero),
    .lastByte(lastByte),
    .opValid (opValid),
    .opKind  (opKind),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .error   (error)
  );

  otp_rd_datapath #(
    .ROW_CYCLES(ROW_CYCLES),
    .LEN_W     (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pageAddr (pageAddr),
    .byteCount(byteCount),
    .opRdata  (opRdata),
    .opByte   (opByte),
    .lenZero  (lenZero),
    .lastByte (lastByte),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: tb/sim_otp_param_reader.sv
`timescale 1ns/1ps
module sim_otp_param_reader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pageAddr = '0;
  logic [15:0] byteCount = '0;
  logic        opValid;
  logic [1:0]  opKind;
  logic [7:0]  opByte;
  logic        opAck = 1'b0;
  logic        opFail = 1'b0;
  logic [7:0]  opRdata = '0;
  logic        rbReady = 1'b1;
  logic [7:0]  dataOut;
  logic        dataValid;
  logic        busy;
  logic        done;
  logic        error;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  int errCnt = 0;
  int dvCnt = 0;

  int    expKind [0:1023];
  int    expByte [0:1023];
  string expTag  [0:1023];
  int    nExp;

  always #2 clk = ~clk;

  otp_param_reader u0 (
    .clk(clk), .rstN(rstN), .start(start), .pageAddr(pageAddr),
    .byteCount(byteCount), .opValid(opValid), .opKind(opKind),
    .opByte(opByte), .opAck(opAck), .opFail(opFail), .opRdata(opRdata),
    .rbReady(rbReady), .dataOut(dataOut), .dataValid(dataValid),
    .busy(busy), .done(done), .error(error)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneCnt++;
      if (error) errCnt++;
      if (dataValid) dvCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic addOp(input int k, input int b, input string t);
    expKind[nExp] = k;
    expByte[nExp] = b;
    expTag[nExp]  = t;
    nExp++;
  endtask

  // expected operation list (waits are not operations)
  task automatic buildExp(input int page, input int len);
    nExp = 0;
    addOp(0, 'hFF, "R2"); addOp(0, 'h36, "R2"); addOp(1, 'h38, "R2");
    addOp(2, 'h52, "R2"); addOp(0, 'h16, "R2");
    addOp(0, 'h17, "R3"); addOp(0, 'h04, "R3"); addOp(0, 'h19, "R3");
    addOp(0, 'h00, "R4"); addOp(1, 0, "R4"); addOp(1, 0, "R4");
    addOp(1, page & 'hFF, "R4"); addOp(1, (page >> 8) & 'hFF, "R4");
    addOp(1, (page >> 16) & 'hFF, "R4"); addOp(0, 'h30, "R4");
    for (int i = 0; i < len; i++) addOp(3, 0, "R5");
    addOp(0, 'hFF, "R6"); addOp(0, 'h36, "R6"); addOp(1, 'h38, "R6");
    addOp(2, 'h00, "R6"); addOp(0, 'h16, "R6"); addOp(0, 'h00, "R6");
    for (int i = 0; i < 5; i++) addOp(1, 0, "R6");
    addOp(0, 'h30, "R6");
  endtask

  task automatic runOne(input int page, input int len, input int failAt,
                        input bit midStart, input string doneTag);
    int  tmo;
    int  hold;
    int  rb;
    bit  aborted;
    buildExp(page, len);
    doneCnt = 0; errCnt = 0; dvCnt = 0;
    aborted = 1'b0;
    @(negedge clk);
    pageAddr  = 24'(page);
    byteCount = 16'(len);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pageAddr  = 24'h5A5A5A;
    byteCount = 16'd3;
    for (int i = 0; i < nExp; i++) begin
      tmo = 0;
      while (!opValid && tmo < 200) begin @(negedge clk); tmo++; end
      if (!opValid) begin
        check(1'b0, expTag[i], "operation missing", i, nExp);
        aborted = 1'b1;
        break;
      end
      check(int'(opKind) == expKind[i], expTag[i], "op kind", opKind, expKind[i]);
      if (expKind[i] != 3)
        check(int'(opByte) == expByte[i], expTag[i], "op byte", opByte, expByte[i]);
      if (midStart && i == 4) start = 1'b1;
      hold = $urandom_range(0, 2);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        start = 1'b0;
        check(opValid && int'(opKind) == expKind[i], "R10", "held op kind", opKind, expKind[i]);
      end
      opAck  = 1'b1;
      opFail = (i == failAt);
      rb = $urandom_range(0, 255);
      opRdata = 8'(rb);
      if (expKind[i] == 0 && (expByte[i] == 'hFF || expByte[i] == 'h30) && i != failAt)
        rbReady = 1'b0;
      @(negedge clk);
      opAck = 1'b0; opFail = 1'b0; start = 1'b0;
      if (i == failAt) begin
        check(error == 1'b1, "R8", "error pulse", error, 1);
        check(busy == 1'b0, "R8", "busy after abort", busy, 0);
        for (int w = 0; w < 10; w++) begin
          @(negedge clk);
          check(!opValid, "R8", "op after abort", opValid, 0);
        end
        check(doneCnt == 0, "R8", "done after abort", doneCnt, 0);
        check(errCnt == 1, "R8", "error pulses", errCnt, 1);
        aborted = 1'b1;
        break;
      end
      if (expKind[i] == 3)
        check(dataValid && int'(dataOut) == rb, "R5", "read byte", dataOut, rb);
      if (!rbReady) begin
        hold = $urandom_range(1, 4);
        for (int h = 0; h < hold; h++) begin
          check(!opValid && busy, "R11", "op during wait", opValid, 0);
          @(negedge clk);
        end
        rbReady = 1'b1;
      end
    end
    if (!aborted) begin
      tmo = 0;
      while (!done && tmo < 20) begin @(negedge clk); tmo++; end
      check(done == 1'b1, doneTag, "done pulse", done, 1);
      check(busy == 1'b0, "R7", "busy with done", busy, 0);
      check(error == 1'b0, "R7", "error with done", error, 0);
      @(negedge clk);
      check(done == 1'b0, "R7", "done width", done, 0);
      check(doneCnt == 1, doneTag, "done count", doneCnt, 1);
      check(dvCnt == len, "R5", "byte count", dvCnt, len);
    end
    rbReady = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (5) @(negedge clk);
    check(!busy && !done && !error && !dataValid && !opValid, "R1",
          "reset outputs", {busy, done, error, dataValid, opValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!opValid && !busy, "R1", "idle outputs", opValid, 0);

    runOne('h21F, 784, -1, 1'b0, "R7");
    runOne('h200, 528, -1, 1'b0, "R7");
    runOne('hABCDEF, 0, -1, 1'b0, "R5");
    runOne('h123456, 1, -1, 1'b0, "R7");
    for (int r = 0; r < 6; r++)
      runOne(int'($urandom_range(0, 24'hFFFFFF)), int'($urandom_range(1, 20)),
             -1, 1'b0, "R7");
    runOne('h3C00A5, 6, -1, 1'b1, "R9");
    runOne('h000111, 8, 3, 1'b0, "R8");
    runOne('h000222, 8, 17, 1'b0, "R8");
    runOne('h000333, 4, 15 + 4 + 12 - 1, 1'b0, "R8");
    runOne('h070707, 2, -1, 1'b0, "R7");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule